// File: doc/BRIEF.md
# Audio Ring-Buffer DMA Pointer Engine

This block moves 32-bit audio samples between two streams and two circular buffers in system memory. On the capture side, samples arrive on a valid/ready stream and the engine writes them into memory as the producer. On the playback side, the engine reads words from memory as the consumer and presents them on a valid/ready stream. Each direction is described by a register set: an enable, a base address, a buffer size and two byte-offset indices, one owned by software and one owned by the hardware.

The ring always keeps one word slot empty. Because of this, equal indices always mean empty and the buffer can never become full. The capture producer stalls instead of overrunning the software consumer. When the playback ring is empty, the engine emits zero samples. Each direction paces its interrupt by a programmable period. Capture counts whole frames of interleaved channels, and playback counts fetch operations. A separate small register window holds a mask and write-1-to-clear pending bits, and drives one interrupt line. Memory is reached through a single-word request/grant port, and one access is outstanding at a time.

Top module: `audio_ring_dma`

## Requirements
- R1: Core window: playback enable 0x00 (bit 0), base 0x04, size 0x08, producer 0x0C, consumer 0x10. Capture enable 0x14, base 0x18, size 0x1C, producer 0x20, consumer 0x24. Software writes only the playback producer and the capture consumer, and each stored value is masked to (size-1) with bits [1:0] cleared. Writes to the hardware-owned indices are ignored. All of these registers read back and are zero after reset.
- R2: The capture path writes each accepted sample to base+producer, then advances the producer by 4 and wraps it by masking with size-1.
- R3: Capture never advances its producer onto the consumer. While (producer+4)&(size-1) equals the consumer, cap_ready is low. The path resumes once software moves the consumer.
- R4: The playback path issues a read at base+consumer only while the consumer differs from the producer. It then advances the consumer by 4 with the same wrap and delivers the word on the playback stream, in order.
- R5: While playback is enabled and no fetched word is held, pb_valid stays high and pb_data is zero.
- R6: A write to 0x2C with bit 0 set resets capture, and with bit 1 set resets playback. The reset zeroes both indices of that direction, its period counter and any partial frame or fetch count. Base, size and the other direction are unchanged.
- R7: Register 0x4C holds the capture interrupt enable in bit 0 and the period in bits [31:8]. After each period frames of CHANNELS words each, pending bit 0 is set.
- R8: Register 0x54 uses the same layout for playback and counts fetches of FETCH_WORDS words. Read-only 0x58 returns the fetch size in bytes in bits [23:8]. Read-only 0x50 returns the capture frame size in bytes in bits [23:8].
- R9: In the interrupt window, 0x8 is the mask and 0xC reads the pending bits (bit 0 capture, bit 1 playback). Writing 1s to 0xC clears those bits. irq is the OR of pending AND mask.
- R10: Clearing an enable stops new memory requests, but a word already requested completes. mem_req, mem_we and mem_addr hold stable until mem_gnt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Core window write strobe |
| reg_addr | input | 8 | Core window byte offset |
| reg_wdata | input | 32 | Core window write data |
| reg_rdata | output | 32 | Core window read data (combinational) |
| irq_wr | input | 1 | Interrupt window write strobe |
| irq_addr | input | 4 | Interrupt window byte offset |
| irq_wdata | input | 32 | Interrupt window write data |
| irq_rdata | output | 32 | Interrupt window read data |
| irq | output | 1 | Interrupt line |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = write (capture), 0 = read (playback) |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Grant; the access completes in this cycle |
| mem_rdata | input | 32 | Read data, valid with the grant |
| cap_valid | input | 1 | Capture sample valid |
| cap_data | input | 32 | Capture sample |
| cap_ready | output | 1 | Capture sample accepted when high with valid |
| pb_valid | output | 1 | Playback sample valid |
| pb_data | output | 32 | Playback sample |
| pb_ready | input | 1 | Playback sink ready |

## Verification
Some properties are checked on every cycle. A pending memory request must hold its address and direction until the grant. A new request must follow an enabled capture side or a non-empty playback ring. A capture advance must never land on the consumer. A soft reset must leave the indices at zero, and a period completion must raise its pending bit. The bench scenarios cover what needs a full sequence to show. These are the exact words written across a wrap, the stall point and its release, the frame and fetch counts at which interrupts fire, the zero fill, the masking of software index writes, and that a soft reset clears a partly counted period.

// File: rtl/adma_pkg.sv
package adma_pkg;
  localparam int SZ_W  = 22;   // buffer size up to 0x200000 bytes
  localparam int PER_W = 24;   // period field bits [31:8]

  localparam logic [7:0] OFS_PB_EN    = 8'h00;
  localparam logic [7:0] OFS_PB_BASE  = 8'h04;
  localparam logic [7:0] OFS_PB_SIZE  = 8'h08;
  localparam logic [7:0] OFS_PB_PROD  = 8'h0C;
  localparam logic [7:0] OFS_PB_CONS  = 8'h10;
  localparam logic [7:0] OFS_CP_EN    = 8'h14;
  localparam logic [7:0] OFS_CP_BASE  = 8'h18;
  localparam logic [7:0] OFS_CP_SIZE  = 8'h1C;
  localparam logic [7:0] OFS_CP_PROD  = 8'h20;
  localparam logic [7:0] OFS_CP_CONS  = 8'h24;
  localparam logic [7:0] OFS_SRST     = 8'h2C;
  localparam logic [7:0] OFS_CP_ICFG  = 8'h4C;
  localparam logic [7:0] OFS_CP_UNIT  = 8'h50;
  localparam logic [7:0] OFS_PB_ICFG  = 8'h54;
  localparam logic [7:0] OFS_PB_UNIT  = 8'h58;

  localparam logic [3:0] OFS_IRQ_MASK = 4'h8;
  localparam logic [3:0] OFS_IRQ_PEND = 4'hC;

  typedef enum logic [1:0] {ARB_IDLE, ARB_CAP, ARB_PB} arb_t;

  // next word slot in the ring
  function automatic logic [SZ_W-1:0] ring_step(input logic [SZ_W-1:0] idx,
                                                input logic [SZ_W-1:0] size);
    return (idx + SZ_W'(4)) & (size - SZ_W'(1));
  endfunction

  // producer may not step onto the consumer
  function automatic logic ring_blocked(input logic [SZ_W-1:0] prod,
                                        input logic [SZ_W-1:0] cons,
                                        input logic [SZ_W-1:0] size);
    return ring_step(prod, size) == cons;
  endfunction

  // software-written index: inside the ring and word aligned
  function automatic logic [SZ_W-1:0] sw_index(input logic [SZ_W-1:0] val,
                                               input logic [SZ_W-1:0] size);
    return val & (size - SZ_W'(1)) & ~SZ_W'(3);
  endfunction

  function automatic logic period_done(input logic [PER_W-1:0] count,
                                       input logic [PER_W-1:0] period);
    return (count + PER_W'(1)) >= period;
  endfunction
endpackage

// File: rtl/adma_regs.sv
module adma_regs
  import adma_pkg::*;
#(
  parameter int CHANNELS    = 2,
  parameter int FETCH_WORDS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [7:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              cap_adv,
  input  logic              pb_adv,
  output logic              cap_en,
  output logic [31:0]       cap_base,
  output logic [SZ_W-1:0]   cap_size,
  output logic [SZ_W-1:0]   cap_prod,
  output logic [SZ_W-1:0]   cap_cons,
  output logic              pb_en,
  output logic [31:0]       pb_base,
  output logic [SZ_W-1:0]   pb_size,
  output logic [SZ_W-1:0]   pb_prod,
  output logic [SZ_W-1:0]   pb_cons,
  output logic              cap_ien,
  output logic [PER_W-1:0]  cap_per,
  output logic              pb_ien,
  output logic [PER_W-1:0]  pb_per,
  output logic              srst_cap,
  output logic              srst_pb
);
  localparam logic [15:0] CAP_UNIT_BYTES = 16'(CHANNELS * 4);
  localparam logic [15:0] PB_UNIT_BYTES  = 16'(FETCH_WORDS * 4);

  logic wr_cap_cons, wr_pb_prod;

  assign srst_cap    = wr && addr == OFS_SRST && wdata[0];
  assign srst_pb     = wr && addr == OFS_SRST && wdata[1];
  assign wr_cap_cons = wr && addr == OFS_CP_CONS;
  assign wr_pb_prod  = wr && addr == OFS_PB_PROD;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_en <= 1'b0; cap_base <= '0; cap_size <= '0;
      pb_en  <= 1'b0; pb_base  <= '0; pb_size  <= '0;
      cap_ien <= 1'b0; cap_per <= '0; pb_ien <= 1'b0; pb_per <= '0;
    end else if (wr) begin
      case (addr)
        OFS_PB_EN:   pb_en    <= wdata[0];
        OFS_PB_BASE: pb_base  <= wdata;
        OFS_PB_SIZE: pb_size  <= wdata[SZ_W-1:0];
        OFS_CP_EN:   cap_en   <= wdata[0];
        OFS_CP_BASE: cap_base <= wdata;
        OFS_CP_SIZE: cap_size <= wdata[SZ_W-1:0];
        OFS_CP_ICFG: begin cap_ien <= wdata[0]; cap_per <= wdata[31:8]; end
        OFS_PB_ICFG: begin pb_ien  <= wdata[0]; pb_per  <= wdata[31:8]; end
        default: ;
      endcase
    end
  end

  // indices: soft reset wins over any update in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n || srst_cap) begin
      cap_prod <= '0;
      cap_cons <= '0;
    end else begin
      if (cap_adv)     cap_prod <= ring_step(cap_prod, cap_size);
      if (wr_cap_cons) cap_cons <= sw_index(wdata[SZ_W-1:0], cap_size);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || srst_pb) begin
      pb_prod <= '0;
      pb_cons <= '0;
    end else begin
      if (pb_adv)     pb_cons <= ring_step(pb_cons, pb_size);
      if (wr_pb_prod) pb_prod <= sw_index(wdata[SZ_W-1:0], pb_size);
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_PB_EN:   rdata = {31'b0, pb_en};
      OFS_PB_BASE: rdata = pb_base;
      OFS_PB_SIZE: rdata = 32'(pb_size);
      OFS_PB_PROD: rdata = 32'(pb_prod);
      OFS_PB_CONS: rdata = 32'(pb_cons);
      OFS_CP_EN:   rdata = {31'b0, cap_en};
      OFS_CP_BASE: rdata = cap_base;
      OFS_CP_SIZE: rdata = 32'(cap_size);
      OFS_CP_PROD: rdata = 32'(cap_prod);
      OFS_CP_CONS: rdata = 32'(cap_cons);
      OFS_CP_ICFG: rdata = {cap_per, 7'b0, cap_ien};
      OFS_CP_UNIT: rdata = {8'b0, CAP_UNIT_BYTES, 8'b0};
      OFS_PB_ICFG: rdata = {pb_per, 7'b0, pb_ien};
      OFS_PB_UNIT: rdata = {8'b0, PB_UNIT_BYTES, 8'b0};
      default:     rdata = '0;
    endcase
  end

  // R3: a hardware capture advance never lands on the consumer
  a_r3_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_adv && !wr_cap_cons && !srst_cap) |=> (cap_prod != cap_cons));

  // R6: soft reset leaves both indices of the direction at zero
  a_r6_srst_cap: assert property (@(posedge clk) disable iff (!rst_n)
    srst_cap |=> (cap_prod == '0 && cap_cons == '0));
  a_r6_srst_pb: assert property (@(posedge clk) disable iff (!rst_n)
    srst_pb |=> (pb_prod == '0 && pb_cons == '0));
endmodule

// File: rtl/adma_pacer.sv
module adma_pacer
  import adma_pkg::*;
#(
  parameter int UNIT_WORDS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             word_done,
  input  logic             en,
  input  logic [PER_W-1:0] period,
  output logic             fire
);
  logic             unit_tick;
  logic [PER_W-1:0] count;

  generate
    if (UNIT_WORDS == 1) begin : g_single
      assign unit_tick = word_done;
    end else begin : g_multi
      localparam int WC_W = $clog2(UNIT_WORDS);
      logic [WC_W-1:0] wc;
      always_ff @(posedge clk) begin
        if (!rst_n || clr)      wc <= '0;
        else if (word_done)     wc <= (wc == WC_W'(UNIT_WORDS - 1)) ? '0 : wc + WC_W'(1);
      end
      assign unit_tick = word_done && wc == WC_W'(UNIT_WORDS - 1);
    end
  endgenerate

  assign fire = unit_tick && en && period != '0 && period_done(count, period);

  always_ff @(posedge clk) begin
    if (!rst_n || clr)                     count <= '0;
    else if (unit_tick && en && period != '0)
      count <= fire ? '0 : count + PER_W'(1);
  end

  // R7: a completed period only follows a completed unit while enabled
  a_r7_fire_gated: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (word_done && en));
endmodule

// File: rtl/adma_irq.sv
module adma_irq
  import adma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic [1:0]  set,
  output logic        irq
);
  logic [1:0] mask, pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '0;
      pend <= '0;
    end else begin
      if (wr && addr == OFS_IRQ_MASK) mask <= wdata[1:0];
      // a new event wins over a clear in the same cycle
      pend <= (pend & ~((wr && addr == OFS_IRQ_PEND) ? wdata[1:0] : 2'b00)) | set;
    end
  end

  always_comb begin
    case (addr)
      OFS_IRQ_MASK: rdata = {30'b0, mask};
      OFS_IRQ_PEND: rdata = {30'b0, pend};
      default:      rdata = '0;
    endcase
  end

  assign irq = |(pend & mask);

  // R9: an event always shows as pending in the next cycle
  a_r9_cap_pend: assert property (@(posedge clk) disable iff (!rst_n)
    set[0] |=> pend[0]);
  a_r9_pb_pend: assert property (@(posedge clk) disable iff (!rst_n)
    set[1] |=> pend[1]);
endmodule

// File: rtl/audio_ring_dma.sv
module audio_ring_dma
  import adma_pkg::*;
#(
  parameter int CHANNELS    = 2,
  parameter int FETCH_WORDS = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        irq_wr,
  input  logic [3:0]  irq_addr,
  input  logic [31:0] irq_wdata,
  output logic [31:0] irq_rdata,
  output logic        irq,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_gnt,
  input  logic [31:0] mem_rdata,
  input  logic        cap_valid,
  input  logic [31:0] cap_data,
  output logic        cap_ready,
  output logic        pb_valid,
  output logic [31:0] pb_data,
  input  logic        pb_ready
);
  logic              cap_en, pb_en, cap_ien, pb_ien, srst_cap, srst_pb;
  logic [31:0]       cap_base, pb_base;
  logic [SZ_W-1:0]   cap_size, cap_prod, cap_cons, pb_size, pb_prod, pb_cons;
  logic [PER_W-1:0]  cap_per, pb_per;
  logic              cap_adv, pb_adv, cap_fire, pb_fire;

  // named internal events
  logic        cap_stall, cap_take, cap_want, pb_want, word_done;
  logic        cap_full, pb_full, discard;
  logic [31:0] cap_buf, pb_buf, addr_q;
  arb_t        state;

  adma_regs #(.CHANNELS(CHANNELS), .FETCH_WORDS(FETCH_WORDS)) u_regs (
    .clk, .rst_n, .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .cap_adv, .pb_adv,
    .cap_en, .cap_base, .cap_size, .cap_prod, .cap_cons,
    .pb_en, .pb_base, .pb_size, .pb_prod, .pb_cons,
    .cap_ien, .cap_per, .pb_ien, .pb_per, .srst_cap, .srst_pb
  );

  adma_pacer #(.UNIT_WORDS(CHANNELS)) u_cap_pace (
    .clk, .rst_n, .clr(srst_cap), .word_done(cap_adv),
    .en(cap_ien), .period(cap_per), .fire(cap_fire)
  );

  adma_pacer #(.UNIT_WORDS(FETCH_WORDS)) u_pb_pace (
    .clk, .rst_n, .clr(srst_pb), .word_done(pb_adv),
    .en(pb_ien), .period(pb_per), .fire(pb_fire)
  );

  adma_irq u_irq (
    .clk, .rst_n, .wr(irq_wr), .addr(irq_addr), .wdata(irq_wdata),
    .rdata(irq_rdata), .set({pb_fire, cap_fire}), .irq
  );

  // capture side
  assign cap_stall = ring_blocked(cap_prod, cap_cons, cap_size);
  assign cap_ready = cap_en && !cap_full && !cap_stall && state != ARB_CAP;
  assign cap_take  = cap_valid && cap_ready;
  assign cap_want  = cap_en && cap_full && !cap_stall && !srst_cap;

  // playback side
  assign pb_want   = pb_en && !pb_full && pb_cons != pb_prod && !srst_pb;

  // access completion
  assign word_done = state != ARB_IDLE && mem_gnt;
  assign cap_adv   = word_done && state == ARB_CAP && !discard;
  assign pb_adv    = word_done && state == ARB_PB  && !discard;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ARB_IDLE;
      discard <= 1'b0;
      addr_q  <= '0;
    end else if (state == ARB_IDLE) begin
      discard <= 1'b0;
      if (cap_want) begin
        state  <= ARB_CAP;
        addr_q <= cap_base + 32'(cap_prod);
      end else if (pb_want) begin
        state  <= ARB_PB;
        addr_q <= pb_base + 32'(pb_cons);
      end
    end else if (mem_gnt) begin
      state   <= ARB_IDLE;
      discard <= 1'b0;
    end else if ((state == ARB_CAP && srst_cap) || (state == ARB_PB && srst_pb)) begin
      discard <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || srst_cap) begin
      cap_full <= 1'b0;
      cap_buf  <= '0;
    end else if (cap_take) begin
      cap_full <= 1'b1;
      cap_buf  <= cap_data;
    end else if (word_done && state == ARB_CAP) begin
      cap_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || srst_pb) begin
      pb_full <= 1'b0;
      pb_buf  <= '0;
    end else if (pb_adv) begin
      pb_full <= 1'b1;
      pb_buf  <= mem_rdata;
    end else if (pb_valid && pb_ready && pb_full) begin
      pb_full <= 1'b0;
    end
  end

  assign mem_req   = state != ARB_IDLE;
  assign mem_we    = state == ARB_CAP;
  assign mem_addr  = addr_q;
  assign mem_wdata = cap_buf;
  assign pb_valid  = pb_en;
  assign pb_data   = pb_full ? pb_buf : 32'h0;

  // R10: a request holds its address and direction until granted
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R10: a new capture write follows an enabled capture side
  a_r10_cap_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_req) && mem_we) |-> $past(cap_en));
  // R4: a new playback read only starts on a non-empty ring
  a_r4_read_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_req) && !mem_we) |-> $past(pb_cons != pb_prod));
endmodule

// File: tb/sim_audio_ring_dma.sv
`timescale 1ns/1ps
module sim_audio_ring_dma;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0, irq_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, irq_wdata = '0;
  logic [3:0]  irq_addr = '0;
  logic [31:0] reg_rdata, irq_rdata, mem_addr, mem_wdata, mem_rdata, cap_data, pb_data;
  logic        irq, mem_req, mem_we, mem_gnt, cap_ready, pb_valid;
  logic        cap_valid = 1'b0, pb_ready = 1'b1, gnt_en = 1'b1;

  int tests = 0, fails = 0;
  int sent;
  int nzc, zc;
  logic [31:0] nz [0:15];
  logic [31:0] mem [0:127];

  always #(CLK_P/2) clk = ~clk;

  audio_ring_dma #(.CHANNELS(2), .FETCH_WORDS(1)) u0 (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .irq_wr, .irq_addr, .irq_wdata, .irq_rdata, .irq,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_gnt, .mem_rdata,
    .cap_valid, .cap_data, .cap_ready, .pb_valid, .pb_data, .pb_ready
  );

  // memory model: playback region 0x100..0x10F returns 0xB000 + word index
  assign mem_gnt   = mem_req & gnt_en;
  assign mem_rdata = (mem_addr >= 32'h100 && mem_addr < 32'h110)
                     ? 32'hB000 + ((mem_addr - 32'h100) >> 2) : mem[mem_addr[8:2]];
  always @(posedge clk) if (mem_req && mem_gnt && mem_we) mem[mem_addr[8:2]] <= mem_wdata;

  // capture source: sample value is 0xA000 + number already accepted
  assign cap_data = 32'hA000 + sent;
  always @(posedge clk) begin
    if (!rst_n) sent <= 0;
    else if (cap_valid && cap_ready) sent <= sent + 1;
  end

  // playback sink
  always @(posedge clk) begin
    if (!rst_n) begin nzc <= 0; zc <= 0; end
    else if (pb_valid && pb_ready) begin
      if (pb_data != 0) begin nz[nzc[3:0]] <= pb_data; nzc <= nzc + 1; end
      else zc <= zc + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic iwr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); irq_wr = 1'b1; irq_addr = a; irq_wdata = d;
    @(negedge clk); irq_wr = 1'b0;
  endtask

  task automatic rchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); reg_addr = a; #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic ichk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk); irq_addr = a; #1;
    chk(tag, irq_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = '0;
    idle(3); rst_n = 1'b1; idle(1);

    // R1 reset state
    for (int a = 0; a <= 'h24; a += 4) rchk("R1 reset reg", 8'(a), 32'h0);
    ichk("R9 reset pending", 4'hC, 32'h0);
    chk("R9 reset irq", {31'b0, irq}, 32'h0);
    chk("R10 reset mem_req", {31'b0, mem_req}, 32'h0);
    chk("R3 reset cap_ready", {31'b0, cap_ready}, 32'h0);
    chk("R5 reset pb_valid", {31'b0, pb_valid}, 32'h0);
    // R8 unit registers
    rchk("R8 fetch bytes", 8'h58, 32'h0000_0400);
    rchk("R8 frame bytes", 8'h50, 32'h0000_0800);

    // capture configuration: base 0x40, 32 bytes, period 3 frames
    wr(8'h18, 32'h40); wr(8'h1C, 32'h20); wr(8'h24, 32'h0); wr(8'h4C, 32'h301);
    wr(8'h20, 32'h8);
    rchk("R1 cap base", 8'h18, 32'h40);
    rchk("R1 cap size", 8'h1C, 32'h20);
    rchk("R7 cap icfg", 8'h4C, 32'h301);
    rchk("R1 hw index write ignored", 8'h20, 32'h0);

    cap_valid = 1'b1;
    wr(8'h14, 32'h1);
    idle(60);
    chk("R3 stall count", 32'(sent), 32'd7);
    chk("R3 stalled ready", {31'b0, cap_ready}, 32'h0);
    rchk("R2 cap prod", 8'h20, 32'h1C);
    for (int k = 0; k < 7; k++) chk("R2 cap word", mem[16 + k], 32'hA000 + 32'(k));
    ichk("R7 pending after 3 frames", 4'hC, 32'h1);
    chk("R9 masked irq", {31'b0, irq}, 32'h0);
    iwr(4'h8, 32'h1);
    chk("R9 unmasked irq", {31'b0, irq}, 32'h1);
    iwr(4'hC, 32'h1);
    ichk("R9 cleared", 4'hC, 32'h0);
    chk("R9 irq low", {31'b0, irq}, 32'h0);

    // release to 16: producer wraps and stops at 12
    wr(8'h24, 32'h10);
    idle(40);
    chk("R3 resumed count", 32'(sent), 32'd11);
    rchk("R2 wrapped prod", 8'h20, 32'h0C);
    chk("R2 slot 7", mem[23], 32'hA007);
    for (int k = 0; k < 3; k++) chk("R2 wrap word", mem[16 + k], 32'hA008 + 32'(k));
    ichk("R7 no fire at 5 frames", 4'hC, 32'h0);

    wr(8'h24, 32'h0);
    idle(40);
    chk("R3 count 15", 32'(sent), 32'd15);
    rchk("R2 prod 0x1C", 8'h20, 32'h1C);
    for (int k = 0; k < 4; k++) chk("R2 word", mem[19 + k], 32'hA00B + 32'(k));
    ichk("R7 fire at 6 frames", 4'hC, 32'h1);
    iwr(4'hC, 32'h1);

    // R10 disable
    wr(8'h14, 32'h0);
    idle(10);
    chk("R10 disabled count", 32'(sent), 32'd15);
    chk("R10 disabled no req", {31'b0, mem_req}, 32'h0);

    // R6 capture soft reset
    wr(8'h2C, 32'h1);
    rchk("R6 prod zero", 8'h20, 32'h0);
    rchk("R6 cons zero", 8'h24, 32'h0);
    rchk("R6 base kept", 8'h18, 32'h40);
    rchk("R6 size kept", 8'h1C, 32'h20);

    // R10 request hold while grant withheld, then disable mid-flight
    wr(8'h24, 32'h14);
    gnt_en = 1'b0;
    wr(8'h14, 32'h1);
    idle(6);
    chk("R10 req held", {31'b0, mem_req}, 32'h1);
    chk("R10 req write", {31'b0, mem_we}, 32'h1);
    chk("R10 req addr", mem_addr, 32'h40);
    wr(8'h14, 32'h0);
    gnt_en = 1'b1;
    idle(10);
    rchk("R10 word completed", 8'h20, 32'h4);
    chk("R10 no further req", {31'b0, mem_req}, 32'h0);
    chk("R10 one accepted", 32'(sent), 32'd16);
    chk("R10 word data", mem[16], 32'hA00F);

    wr(8'h14, 32'h1);
    idle(40);
    chk("R3 count 19", 32'(sent), 32'd19);
    rchk("R3 stop before 0x14", 8'h20, 32'h10);
    ichk("R6 period counter cleared", 4'hC, 32'h0);
    wr(8'h24, 32'h0);
    idle(40);
    chk("R3 count 22", 32'(sent), 32'd22);
    ichk("R7 fire after 3 frames", 4'hC, 32'h1);
    wr(8'h14, 32'h0);
    cap_valid = 1'b0;
    iwr(4'hC, 32'h1);

    // playback: base 0x100, 16 bytes, period 2 fetches
    wr(8'h04, 32'h100); wr(8'h08, 32'h10); wr(8'h0C, 32'hC); wr(8'h54, 32'h201);
    iwr(4'h8, 32'h3);
    wr(8'h00, 32'h1);
    idle(40);
    chk("R4 words delivered", 32'(nzc), 32'd3);
    for (int k = 0; k < 3; k++) chk("R4 word order", nz[k], 32'hB000 + 32'(k));
    chk("R5 zeros seen", {31'b0, zc > 0}, 32'h1);
    chk("R5 zero when empty", pb_data, 32'h0);
    rchk("R4 cons", 8'h10, 32'hC);
    ichk("R8 pending after 2 fetches", 4'hC, 32'h2);
    chk("R9 irq playback", {31'b0, irq}, 32'h1);
    iwr(4'hC, 32'h2);
    wr(8'h0C, 32'h4);
    idle(40);
    chk("R4 wrapped count", 32'(nzc), 32'd5);
    chk("R4 word 3", nz[3], 32'hB003);
    chk("R4 word wrap", nz[4], 32'hB000);
    rchk("R4 cons wrapped", 8'h10, 32'h4);
    ichk("R8 pending after 4 fetches", 4'hC, 32'h2);
    iwr(4'hC, 32'h2);
    wr(8'h0C, 32'h1B);
    rchk("R1 masked sw index", 8'h0C, 32'h8);
    idle(20);
    chk("R4 count 6", 32'(nzc), 32'd6);
    chk("R4 word 5", nz[5], 32'hB001);
    rchk("R4 cons 8", 8'h10, 32'h8);

    // R6 playback soft reset
    wr(8'h00, 32'h0);
    wr(8'h2C, 32'h2);
    rchk("R6 pb prod zero", 8'h0C, 32'h0);
    rchk("R6 pb cons zero", 8'h10, 32'h0);
    rchk("R6 pb base kept", 8'h04, 32'h100);
    rchk("R6 capture untouched", 8'h20, 32'h1C);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule